// File: doc/BRIEF.md
# Serial Sample Lane Framer

The framer takes one parallel converter sample per frame and sends it out as a serial word on a single double-data-rate lane. It runs from a bit-rate clock at half the serial bit rate, so every clock cycle carries two serial bits. These are presented as a pair, `ser_pair[1]` first in time and `ser_pair[0]` second. A full 14-bit word takes seven cycles. A frame marker travels with the data in the same two-bit form. A data-clock waveform, sampled at six sub-slots per cycle, gives the receiver's capture clock at a programmable phase in 60-degree steps.

Before serialization each sample is formatted. It can be sent as offset binary or twos complement, every bit can be inverted, and the bit order can be MSB-first or LSB-first. The word can also be cut down to 12, 10 or 8 bits. A shorter word keeps the top bits of the sample, and the frame shortens with it. The word length is taken at the clock edge that starts a frame, so a change during a frame never tears the word in flight.

The sample input is valid/ready. `in_ready` is high in the last cycle of each frame only. A sample moves when `in_valid` and `in_ready` are both high at a rising edge. A source with `in_valid` high and `in_ready` low must hold `in_data` steady. If no sample is offered at a frame start, the last accepted sample is sent again, so the lane never idles. Configuration inputs are plain levels.

Top module: `ser_lane_framer`

## Requirements
- R1: While reset is high, `ser_pair` and `frame_pair` are 00, `in_ready` is 1, and `dclk_wave` is 6'b111000 (the 180-degree pattern).
- R2: With `cfg_fmt`=00, `cfg_invert`=0, `cfg_lsb_first`=0 and `cfg_wlen`=00, the accepted 14-bit sample is sent MSB first, two bits per cycle (`ser_pair[1]` earlier), over the 7 cycles that follow the accepting edge. Words follow each other with no gap.
- R3: `in_ready` is high in exactly the last cycle of every frame and low in all other cycles. The sample is accepted at the edge that ends that cycle.
- R4: When `in_valid` is low at a frame start, the frame carries the last accepted sample. It is formatted with the configuration present at that edge, and `in_data` is ignored.
- R5: `cfg_fmt`=01 selects twos complement, which inverts sample bit 13. Codes 00, 10 and 11 send offset binary unchanged.
- R6: `cfg_invert`=1 complements every transmitted bit. This is applied after the format step.
- R7: `cfg_lsb_first`=1 sends the kept bits of the word lowest-weight first.
- R8: `cfg_wlen` 00/01/10/11 gives words of 14/12/10/8 bits made of sample bits 13 downward, and frames of 7/6/5/4 cycles. The length is taken at the frame-start edge.
- R9: `frame_pair` uses the same bit timing as `ser_pair`. It is 1 for the first half of each word's bits and 0 for the second half.
- R10: `dclk_wave[s]` (s=0 earliest of six slots per cycle, a bit edge at slots 0 and 3) is 1 when (s - c) mod 6 < 3. Here c is the phase code registered one cycle earlier, with codes above 11 treated as 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, half the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Frame-start slot, sample taken at next edge |
| in_data | input | 14 | Parallel sample, offset binary |
| cfg_fmt | input | 2 | Output format code (01 twos complement) |
| cfg_invert | input | 1 | Complement all output bits |
| cfg_lsb_first | input | 1 | Send lowest-weight bit first |
| cfg_wlen | input | 2 | Word length code (14/12/10/8 bits) |
| cfg_dclk_phase | input | 4 | Data clock phase in 60-degree steps |
| ser_pair | output | 2 | Two serial bits of this cycle, [1] first |
| frame_pair | output | 2 | Frame marker for the same two bit slots |
| dclk_wave | output | 6 | Data clock level per sixth of a cycle |

## Verification
The first pair of a word appears in the cycle right after the edge that accepted the sample. Its last pair lies in the cycle where `in_ready` is high again, 7, 6, 5 or 4 cycles later depending on the word length latched at that edge. The data-clock pattern follows a new phase code one edge later. `in_ready` depends only on state, so it can be read at any point in a cycle. The bench drives inputs and samples every output on falling edges. It gathers one pair per falling edge, starting with the first falling edge after the accepting rising edge. It then compares the whole word, the frame marker and the ready pattern against a model computed from the requirements.

// File: rtl/ser_lane_pkg.sv
package ser_lane_pkg;

  typedef struct packed {
    logic [1:0] fmt;
    logic       invert;
    logic       lsb_first;
    logic [1:0] wlen;
  } lane_cfg_t;

  localparam logic [1:0] FMT_TWOS = 2'b01;

endpackage

// File: rtl/ser_lane_format.sv
module ser_lane_format
  import ser_lane_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic [SAMPLE_W-1:0] raw,
  input  lane_cfg_t           cfg,
  output logic [SAMPLE_W-1:0] word
);

  logic [SAMPLE_W-1:0] coded;
  logic [SAMPLE_W-1:0] mirrored;
  logic [2:0]          cut;

  // Twos complement flips the top bit; inversion then complements all bits.
  always_comb begin
    coded = raw;
    if (cfg.fmt == FMT_TWOS) coded[SAMPLE_W-1] = ~coded[SAMPLE_W-1];
    if (cfg.invert) coded = ~coded;
    for (int j = 0; j < SAMPLE_W; j++) mirrored[j] = coded[SAMPLE_W-1-j];
  end

  // Two dropped bits per word-length step; result is left-justified.
  assign cut  = {cfg.wlen, 1'b0};
  assign word = cfg.lsb_first ? (mirrored << cut)
                              : (coded & ({SAMPLE_W{1'b1}} << cut));

endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] word_in,
  input  logic [1:0]          wlen_in,
  output logic [1:0]          pair,
  output logic [1:0]          fco_pair,
  output logic                last
);

  localparam int PAIRS = SAMPLE_W / 2;
  localparam int CNT_W = $clog2(PAIRS);

  logic [SAMPLE_W-1:0] sr;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    last_q;
  logic [CNT_W+1:0]    bit_lo;
  logic [CNT_W+1:0]    bit_hi;
  logic [CNT_W+1:0]    half_bits;

  assign last = (cnt == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      cnt    <= CNT_W'(PAIRS - 1);
      last_q <= CNT_W'(PAIRS - 1);
    end else if (last) begin
      sr     <= word_in;
      cnt    <= '0;
      last_q <= CNT_W'(PAIRS - 1 - int'(wlen_in));
    end else begin
      sr     <= {sr[SAMPLE_W-3:0], 2'b00};
      cnt    <= cnt + CNT_W'(1);
    end
  end

  assign pair = sr[SAMPLE_W-1:SAMPLE_W-2];

  // Word has 2*(last_q+1) bits; marker high for the first last_q+1 of them.
  assign bit_lo    = {1'b0, cnt, 1'b0};
  assign bit_hi    = {1'b0, cnt, 1'b1};
  assign half_bits = {2'b00, last_q} + (CNT_W+2)'(1);
  assign fco_pair  = {bit_lo < half_bits, bit_hi < half_bits};

endmodule

// File: rtl/ser_lane_dclk.sv
module ser_lane_dclk #(
  parameter int PH_W       = 4,
  parameter int STEPS      = 6,
  parameter int PH_MAX     = 11,
  parameter int PH_DEFAULT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_in,
  output logic [STEPS-1:0] wave
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] rot;

  always_ff @(posedge clk) begin
    if (rst)                          ph_q <= PH_W'(PH_DEFAULT);
    else if (phase_in > PH_W'(PH_MAX)) ph_q <= PH_W'(PH_MAX);
    else                              ph_q <= phase_in;
  end

  // Whole turns of the data clock fold onto the same slot pattern.
  assign rot = ph_q % PH_W'(STEPS);

  for (genvar s = 0; s < STEPS; s++) begin : g_slot
    assign wave[s] = ((s + STEPS - int'(rot)) % STEPS) < (STEPS / 2);
  end

endmodule

// File: rtl/ser_lane_framer.sv
module ser_lane_framer
  import ser_lane_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int PH_W       = 4,
  parameter int DCLK_STEPS = 6,
  parameter int PH_MAX     = 11,
  parameter int PH_DEFAULT = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [SAMPLE_W-1:0]   in_data,
  input  logic [1:0]            cfg_fmt,
  input  logic                  cfg_invert,
  input  logic                  cfg_lsb_first,
  input  logic [1:0]            cfg_wlen,
  input  logic [PH_W-1:0]       cfg_dclk_phase,
  output logic [1:0]            ser_pair,
  output logic [1:0]            frame_pair,
  output logic [DCLK_STEPS-1:0] dclk_wave
);

  lane_cfg_t           cfg;
  logic [SAMPLE_W-1:0] held;
  logic [SAMPLE_W-1:0] src;
  logic [SAMPLE_W-1:0] word;

  assign cfg = '{fmt: cfg_fmt, invert: cfg_invert,
                 lsb_first: cfg_lsb_first, wlen: cfg_wlen};

  // Last accepted sample, resent when nothing is offered at a frame start.
  always_ff @(posedge clk) begin
    if (rst)                       held <= '0;
    else if (in_ready && in_valid) held <= in_data;
  end

  assign src = in_valid ? in_data : held;

  ser_lane_format #(.SAMPLE_W(SAMPLE_W)) u_fmt (
    .raw  (src),
    .cfg  (cfg),
    .word (word)
  );

  ser_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .word_in  (word),
    .wlen_in  (cfg_wlen),
    .pair     (ser_pair),
    .fco_pair (frame_pair),
    .last     (in_ready)
  );

  ser_lane_dclk #(
    .PH_W(PH_W), .STEPS(DCLK_STEPS), .PH_MAX(PH_MAX), .PH_DEFAULT(PH_DEFAULT)
  ) u_dclk (
    .clk      (clk),
    .rst      (rst),
    .phase_in (cfg_dclk_phase),
    .wave     (dclk_wave)
  );

endmodule

// File: rtl/ser_lane_framer_chk.sv
module ser_lane_framer_chk #(
  parameter int SAMPLE_W   = 14,
  parameter int DCLK_STEPS = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_ready,
  input logic [1:0]            frame_pair,
  input logic [DCLK_STEPS-1:0] dclk_wave
);

  localparam int MAX_PAIRS = SAMPLE_W / 2;
  localparam int GAP_W     = $clog2(MAX_PAIRS + 1);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || in_ready) gap <= '0;
    else                 gap <= gap + GAP_W'(1);
  end

  assert_ready_single_R3: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  assert_frame_gap_R8: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_W'(MAX_PAIRS - 1));

  assert_word_start_R9: assert property (@(posedge clk) disable iff (rst)
    $past(in_ready & ~rst) |-> frame_pair == 2'b11);

  assert_word_end_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> frame_pair == 2'b00);

  assert_dclk_duty_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(dclk_wave) == DCLK_STEPS / 2);

endmodule

bind ser_lane_framer ser_lane_framer_chk #(
  .SAMPLE_W(SAMPLE_W), .DCLK_STEPS(DCLK_STEPS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .frame_pair (frame_pair),
  .dclk_wave  (dclk_wave)
);

// File: tb/sim_ser_lane_framer.sv
module sim_ser_lane_framer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_data = '0;
  logic [1:0]  cfg_fmt = '0;
  logic        cfg_invert = 1'b0;
  logic        cfg_lsb_first = 1'b0;
  logic [1:0]  cfg_wlen = '0;
  logic [3:0]  cfg_dclk_phase = 4'd3;
  logic [1:0]  ser_pair;
  logic [1:0]  frame_pair;
  logic [5:0]  dclk_wave;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ser_lane_framer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_fmt(cfg_fmt), .cfg_invert(cfg_invert),
    .cfg_lsb_first(cfg_lsb_first), .cfg_wlen(cfg_wlen),
    .cfg_dclk_phase(cfg_dclk_phase), .ser_pair(ser_pair),
    .frame_pair(frame_pair), .dclk_wave(dclk_wave)
  );

  // Row: {sample[13:0], fmt[1:0], invert, lsb_first, wlen[1:0]}
  localparam logic [19:0] VECS [12] = '{
    {14'h2000, 2'd0, 1'b0, 1'b0, 2'd0},
    {14'h1234, 2'd0, 1'b0, 1'b0, 2'd0},
    {14'h3FFF, 2'd0, 1'b0, 1'b0, 2'd0},
    {14'h2000, 2'd1, 1'b0, 1'b0, 2'd0},
    {14'h0ABC, 2'd2, 1'b0, 1'b0, 2'd0},
    {14'h1234, 2'd0, 1'b1, 1'b0, 2'd0},
    {14'h1234, 2'd0, 1'b0, 1'b1, 2'd0},
    {14'h2D5A, 2'd0, 1'b0, 1'b0, 2'd1},
    {14'h2D5A, 2'd0, 1'b0, 1'b1, 2'd2},
    {14'h2D5A, 2'd1, 1'b1, 1'b1, 2'd3},
    {14'h0001, 2'd0, 1'b0, 1'b1, 2'd0},
    {14'h3C0F, 2'd3, 1'b1, 1'b0, 2'd2}
  };

  function automatic logic [13:0] exp_word(input logic [19:0] v);
    logic [13:0] s;
    int n;
    s = v[19:6];
    n = 14 - 2 * int'(v[1:0]);
    if (v[5:4] == 2'd1) s[13] = ~s[13];
    if (v[3]) s = ~s;
    exp_word = '0;
    for (int b = 0; b < n; b++)
      exp_word[b] = v[2] ? s[14 - n + b] : s[13 - b];
  endfunction

  function automatic logic [13:0] exp_frame(input logic [1:0] wlen);
    exp_frame = '0;
    for (int b = 0; b < 7 - int'(wlen); b++) exp_frame[b] = 1'b1;
  endfunction

  function automatic string tag_of(input logic [19:0] v);
    if (v[1:0] != 2'd0) return "R8";
    if (v[2])           return "R7";
    if (v[3])           return "R6";
    if (v[5:4] != 2'd0) return "R5";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Waits for a frame start, offers (or withholds) a sample, gathers the word.
  task automatic xfer(input logic give, input logic [19:0] v, input logic mess,
                      output logic [13:0] got_d, output logic [13:0] got_f,
                      output logic rdy_ok);
    int len;
    while (!in_ready) @(negedge clk);
    in_valid      = give;
    in_data       = give ? v[19:6] : 14'h0F0F;
    cfg_fmt       = v[5:4];
    cfg_invert    = v[3];
    cfg_lsb_first = v[2];
    cfg_wlen      = v[1:0];
    @(negedge clk);
    in_valid = 1'b0;
    len    = 7 - int'(v[1:0]);
    got_d  = '0;
    got_f  = '0;
    rdy_ok = 1'b1;
    for (int c = 0; c < len; c++) begin
      got_d[2*c]     = ser_pair[1];
      got_d[2*c + 1] = ser_pair[0];
      got_f[2*c]     = frame_pair[1];
      got_f[2*c + 1] = frame_pair[0];
      if (in_ready !== (c == len - 1)) rdy_ok = 1'b0;
      if (mess && c == 0) cfg_wlen = ~cfg_wlen;
      if (c < len - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [13:0] gd, gf;
    logic        rok;
    logic [5:0]  ew;
    int          pp;

    // R1: state held in reset
    repeat (3) @(negedge clk);
    chk("R1 ser_pair", 32'(ser_pair), 32'd0);
    chk("R1 frame_pair", 32'(frame_pair), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 dclk_wave", 32'(dclk_wave), 32'h38);
    rst = 1'b0;

    // Table of formatting and length cases, sent back to back
    for (int i = 0; i < 12; i++) begin
      xfer(1'b1, VECS[i], 1'b0, gd, gf, rok);
      chk(tag_of(VECS[i]), 32'(gd), 32'(exp_word(VECS[i])));
      chk("R9 marker", 32'(gf), 32'(exp_frame(VECS[i][1:0])));
      chk("R3 ready slot", 32'(rok), 32'd1);
    end

    // R4: no sample offered, previous sample resent with current format
    xfer(1'b1, {14'h1A5C, 2'd0, 1'b0, 1'b0, 2'd0}, 1'b0, gd, gf, rok);
    chk("R4 first", 32'(gd), 32'(exp_word({14'h1A5C, 2'd0, 1'b0, 1'b0, 2'd0})));
    xfer(1'b0, {14'h1A5C, 2'd0, 1'b1, 1'b0, 2'd0}, 1'b0, gd, gf, rok);
    chk("R4 repeat", 32'(gd), 32'(exp_word({14'h1A5C, 2'd0, 1'b1, 1'b0, 2'd0})));
    chk("R3 repeat ready", 32'(rok), 32'd1);

    // R8: length change inside a frame does not alter the frame in flight
    xfer(1'b1, {14'h3333, 2'd0, 1'b0, 1'b0, 2'd3}, 1'b1, gd, gf, rok);
    chk("R8 latched word", 32'(gd), 32'(exp_word({14'h3333, 2'd0, 1'b0, 1'b0, 2'd3})));
    chk("R8 latched length", 32'(rok), 32'd1);
    chk("R9 short marker", 32'(gf), 32'(exp_frame(2'd3)));

    // R10: data clock phase codes, including codes clamped to 11
    for (int k = 0; k < 9; k++) begin
      case (k)
        0: pp = 0;  1: pp = 1;  2: pp = 3;  3: pp = 5;  4: pp = 6;
        5: pp = 10; 6: pp = 11; 7: pp = 13; default: pp = 15;
      endcase
      cfg_dclk_phase = 4'(pp);
      @(negedge clk);
      if (pp > 11) pp = 11;
      for (int s = 0; s < 6; s++) ew[s] = ((s - (pp % 6) + 6) % 6) < 3;
      chk("R10 phase", 32'(dclk_wave), 32'(ew));
    end

    done = 1'b1;
    finish_run();
  end

endmodule